// File: doc/BRIEF.md
# Routed Level Interrupt Controller

This block gathers two banks of sixteen level-sensitive interrupt lines. It brings each line into the core clock domain and holds the result as a pending bit. A bank-wide enable word gates the pending bits, and every line that is both pending and enabled is steered to one of five request outputs that go to a processor core. A 3-bit route field chooses the output for a line. Only some lines have such a field. Every other line always drives output 0.

Software reaches the block over a simple synchronous 16-bit register bus. Address, write strobe and write data are sampled on the clock edge. Read data is a combinational function of the address. The block can read back the synchronized pending words, the two enable words and the four route words. It does not prioritise between lines. Each output is only the registered OR of the lines steered to it.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset both enable words read 0x0000 and every bit of `irq_out` is 0.
- R2: A pending word (bank A at 0x00, bank B at 0x20) shows its source inputs two clock edges after they change. Writes to 0x00 and 0x20 do not change what those words read.
- R3: A line affects the outputs only while both its pending bit and its enable bit are 1. `irq_out` is registered and changes one clock edge after a pending or enable change.
- R4: The route fields are 3 bits wide and sit at these positions. Word 0x04 holds bank A lines 0,1,2,3,8 at bits 0,3,6,9,12. Word 0x06 holds bank A lines 9,11,12 at bits 0,6,9. Word 0x1C holds bank B lines 0,1,3,4,5 at bits 0,3,6,9,12. Word 0x1E holds bank B lines 6,7,8,9,10 at bits 0,3,6,9,12. A field value n from 0 to 4 steers the line to `irq_out[n]`.
- R5: If a write puts a value from 5 to 7 into a route field, that field keeps its old value. Legal fields in the same write still update.
- R6: A line that has no route field always drives `irq_out[0]`. Route-word bits that belong to no field read as 0, and writes to them are ignored.
- R7: Each `irq_out[n]` is the OR of all active lines in both banks that are steered to n. Several outputs may be high in the same cycle.
- R8: The enable words (bank A at 0x0C, bank B at 0x26) are fully writable 16-bit registers and read back what was written.
- R9: After reset, route word 0x04 reads 0x0040, which steers bank A line 2 to output 1. Route word 0x1C reads 0x0002, which steers bank B line 0 to output 2. Route words 0x06 and 0x1E read 0x0000.
- R10: Reads from any other address return 0x0000, and writes to any other address change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a | input | 16 | Bank A level interrupt lines |
| src_b | input | 16 | Bank B level interrupt lines |
| bus_addr | input | 6 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| irq_out | output | 5 | Registered request outputs 0..4 |

## Verification
Two kinds of event can hit the same clock edge. One is a register write, either to an enable word or to a route word. The other is a line reaching its pending bit through the synchronizer. When both happen together, the output must be built from the old enable or route value on that edge and from the new value one edge later. A pseudo-random phase causes this overlap: it changes the source lines and issues writes to every register address in the same cycles, and it also writes illegal route values. A behavioural model in the bench tracks pending, enable and route state in integer arrays and predicts `irq_out` for every clock. The read data is compared with the model after each random read.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;
   localparam int ROUTE_REGS = 4;
   localparam int SLOTS      = 5;

   localparam logic [7:0] OFS_PEND_A = 8'h00;
   localparam logic [7:0] OFS_MASK_A = 8'h0C;
   localparam logic [7:0] OFS_PEND_B = 8'h20;
   localparam logic [7:0] OFS_MASK_B = 8'h26;

   typedef struct packed {
      logic       valid;
      logic [1:0] word;
      logic [2:0] slot;
   } field_loc_t;

   function automatic logic [7:0] route_ofs(input int r);
      case (r)
         0:       return 8'h04;
         1:       return 8'h06;
         2:       return 8'h1C;
         default: return 8'h1E;
      endcase
   endfunction

   // which slots of a route word hold a real field
   function automatic logic slot_used(input int r, input int s);
      if (r == 1) return (s == 0) || (s == 2) || (s == 3);
      return 1'b1;
   endfunction

   function automatic logic [2:0] slot_reset(input int r, input int s);
      if (r == 0 && s == 2) return 3'd1;
      if (r == 2 && s == 0) return 3'd2;
      return 3'd0;
   endfunction

   // bank 0 = A, bank 1 = B
   function automatic field_loc_t locate(input int bank, input int pin);
      field_loc_t l;
      l = '0;
      if (bank == 0) begin
         if (pin <= 3) begin l.valid = 1'b1; l.word = 2'd0; l.slot = 3'(pin); end
         else if (pin == 8)  begin l.valid = 1'b1; l.word = 2'd0; l.slot = 3'd4; end
         else if (pin == 9)  begin l.valid = 1'b1; l.word = 2'd1; l.slot = 3'd0; end
         else if (pin == 11) begin l.valid = 1'b1; l.word = 2'd1; l.slot = 3'd2; end
         else if (pin == 12) begin l.valid = 1'b1; l.word = 2'd1; l.slot = 3'd3; end
      end else begin
         if (pin <= 1) begin l.valid = 1'b1; l.word = 2'd2; l.slot = 3'(pin); end
         else if (pin >= 3 && pin <= 5)  begin l.valid = 1'b1; l.word = 2'd2; l.slot = 3'(pin - 1); end
         else if (pin >= 6 && pin <= 10) begin l.valid = 1'b1; l.word = 2'd3; l.slot = 3'(pin - 6); end
      end
      return l;
   endfunction
endpackage

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
module irq_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 1) begin : g_bad
      $error("irq_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_route_regs.sv
`timescale 1ns/1ps
module irq_route_regs
   import irq_route_pkg::*;
#(
   parameter int FIELD_W = 3,
   parameter int NUM_OUT = 5,
   parameter int DATA_W  = 16
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic [ROUTE_REGS-1:0]                         wr_en,
   input  logic [DATA_W-1:0]                             wdata,
   output logic [ROUTE_REGS-1:0][SLOTS-1:0][FIELD_W-1:0] fields,
   output logic [ROUTE_REGS-1:0][DATA_W-1:0]             rd_word
);
   if (SLOTS * FIELD_W > DATA_W) begin : g_bad_fit
      $error("irq_route_regs: fields do not fit in a data word");
   end

   for (genvar r = 0; r < ROUTE_REGS; r++) begin : g_word
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         if (slot_used(r, s)) begin : g_live
            logic [FIELD_W-1:0] val;
            logic [FIELD_W-1:0] cand;
            assign cand = wdata[s*FIELD_W +: FIELD_W];
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  val <= FIELD_W'(slot_reset(r, s));
               else if (wr_en[r] && (int'(cand) < NUM_OUT))
                  val <= cand;
            end
            assign fields[r][s] = val;
         end else begin : g_dead
            assign fields[r][s] = '0;
         end
      end
   end

   always_comb begin
      rd_word = '0;
      for (int r = 0; r < ROUTE_REGS; r++)
         for (int s = 0; s < SLOTS; s++)
            rd_word[r][s*FIELD_W +: FIELD_W] = fields[r][s];
   end
endmodule

// File: rtl/irq_or_stage.sv
`timescale 1ns/1ps
module irq_or_stage #(
   parameter int NUM_SRC = 16,
   parameter int NUM_OUT = 5,
   parameter int FIELD_W = 3
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_SRC-1:0]               act_a,
   input  logic [NUM_SRC-1:0]               act_b,
   input  logic [NUM_SRC-1:0][FIELD_W-1:0]  sel_a,
   input  logic [NUM_SRC-1:0][FIELD_W-1:0]  sel_b,
   output logic [NUM_OUT-1:0]               irq_q
);
   logic [NUM_OUT-1:0] nxt;

   always_comb begin
      nxt = '0;
      for (int k = 0; k < NUM_OUT; k++)
         for (int p = 0; p < NUM_SRC; p++)
            nxt[k] = nxt[k]
                   | (act_a[p] & (sel_a[p] == FIELD_W'(k)))
                   | (act_b[p] & (sel_b[p] == FIELD_W'(k)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= '0;
      else        irq_q <= nxt;
   end
endmodule

// File: rtl/irq_route_ctrl.sv
`timescale 1ns/1ps
module irq_route_ctrl
   import irq_route_pkg::*;
#(
   parameter int NUM_SRC     = 16,
   parameter int NUM_OUT     = 5,
   parameter int FIELD_W     = 3,
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [15:0]        src_a,
   input  logic [15:0]        src_b,
   input  logic [5:0]         bus_addr,
   input  logic               bus_we,
   input  logic [15:0]        bus_wdata,
   output logic [15:0]        bus_rdata,
   output logic [4:0]         irq_out
);
   if (NUM_SRC != 16 || DATA_W != 16 || ADDR_W != 6 || NUM_OUT != 5) begin : g_bad_shape
      $error("irq_route_ctrl: port widths are fixed by the register map");
   end
   if (NUM_OUT > (1 << FIELD_W)) begin : g_bad_field
      $error("irq_route_ctrl: route field too narrow for NUM_OUT");
   end

   localparam logic [ADDR_W-1:0] A_PEND_A = ADDR_W'(OFS_PEND_A);
   localparam logic [ADDR_W-1:0] A_MASK_A = ADDR_W'(OFS_MASK_A);
   localparam logic [ADDR_W-1:0] A_PEND_B = ADDR_W'(OFS_PEND_B);
   localparam logic [ADDR_W-1:0] A_MASK_B = ADDR_W'(OFS_MASK_B);

   logic [NUM_SRC-1:0] pend_a, pend_b;
   logic [NUM_SRC-1:0] mask_a, mask_b;
   logic [ROUTE_REGS-1:0] route_we;
   logic [ROUTE_REGS-1:0] route_hit;
   logic [ROUTE_REGS-1:0][SLOTS-1:0][FIELD_W-1:0] route_f;
   logic [ROUTE_REGS-1:0][DATA_W-1:0] route_rd;
   logic [NUM_SRC-1:0][FIELD_W-1:0] sel_a, sel_b;

   irq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync_a (
      .clk(clk), .rst_n(rst_n), .d(src_a), .q(pend_a));
   irq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync_b (
      .clk(clk), .rst_n(rst_n), .d(src_b), .q(pend_b));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_a <= '0;
         mask_b <= '0;
      end else if (bus_we) begin
         if (bus_addr == A_MASK_A) mask_a <= bus_wdata[NUM_SRC-1:0];
         if (bus_addr == A_MASK_B) mask_b <= bus_wdata[NUM_SRC-1:0];
      end
   end

   for (genvar r = 0; r < ROUTE_REGS; r++) begin : g_dec
      assign route_hit[r] = (bus_addr == ADDR_W'(route_ofs(r)));
      assign route_we[r]  = bus_we & route_hit[r];
   end

   irq_route_regs #(.FIELD_W(FIELD_W), .NUM_OUT(NUM_OUT), .DATA_W(DATA_W)) u_route (
      .clk(clk), .rst_n(rst_n), .wr_en(route_we), .wdata(bus_wdata),
      .fields(route_f), .rd_word(route_rd));

   for (genvar p = 0; p < NUM_SRC; p++) begin : g_sel
      localparam field_loc_t LOC_A = locate(0, p);
      localparam field_loc_t LOC_B = locate(1, p);
      if (LOC_A.valid) begin : g_fa
         assign sel_a[p] = route_f[LOC_A.word][LOC_A.slot];
      end else begin : g_za
         assign sel_a[p] = '0;
      end
      if (LOC_B.valid) begin : g_fb
         assign sel_b[p] = route_f[LOC_B.word][LOC_B.slot];
      end else begin : g_zb
         assign sel_b[p] = '0;
      end
   end

   irq_or_stage #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT), .FIELD_W(FIELD_W)) u_or (
      .clk(clk), .rst_n(rst_n),
      .act_a(pend_a & mask_a), .act_b(pend_b & mask_b),
      .sel_a(sel_a), .sel_b(sel_b), .irq_q(irq_out));

   always_comb begin
      bus_rdata = '0;
      if      (bus_addr == A_PEND_A) bus_rdata = DATA_W'(pend_a);
      else if (bus_addr == A_MASK_A) bus_rdata = DATA_W'(mask_a);
      else if (bus_addr == A_PEND_B) bus_rdata = DATA_W'(pend_b);
      else if (bus_addr == A_MASK_B) bus_rdata = DATA_W'(mask_b);
      else begin
         for (int r = 0; r < ROUTE_REGS; r++)
            if (route_hit[r]) bus_rdata = route_rd[r];
      end
   end
endmodule

// File: rtl/irq_route_chk.sv
`timescale 1ns/1ps
module irq_route_chk
   import irq_route_pkg::*;
#(
   parameter int NUM_SRC     = 16,
   parameter int NUM_OUT     = 5,
   parameter int FIELD_W     = 3,
   parameter int SYNC_STAGES = 2
) (
   input logic                                          clk,
   input logic                                          rst_n,
   input logic [15:0]                                   src_a,
   input logic [15:0]                                   src_b,
   input logic [NUM_SRC-1:0]                            pend_a,
   input logic [NUM_SRC-1:0]                            pend_b,
   input logic [NUM_SRC-1:0]                            mask_a,
   input logic [NUM_SRC-1:0]                            mask_b,
   input logic [ROUTE_REGS-1:0][SLOTS-1:0][FIELD_W-1:0] route_f,
   input logic [5:0]                                    bus_addr,
   input logic [15:0]                                   bus_rdata,
   input logic [4:0]                                    irq_out
);
   logic [3:0] cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cyc <= '0;
      else if (cyc != 4'hF) cyc <= cyc + 4'd1;
   end

   assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 4'd0) |-> (mask_a == '0 && mask_b == '0 && irq_out == '0));

   if (SYNC_STAGES == 2) begin : g_sync_chk
      assert_sync_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (cyc >= 4'd2) |-> (pend_a == $past(src_a, 2) && pend_b == $past(src_b, 2)));
   end

   assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_a & mask_a) == '0 && (pend_b & mask_b) == '0) |=> (irq_out == '0));

   for (genvar r = 0; r < ROUTE_REGS; r++) begin : g_fr
      for (genvar s = 0; s < SLOTS; s++) begin : g_fs
         assert_field_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
            int'(route_f[r][s]) < NUM_OUT);
      end
   end

   assert_unused_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 6'h06) |-> (bus_rdata[5:3] == 3'd0 && bus_rdata[15:12] == 4'd0));

   for (genvar k = 0; k < NUM_OUT; k++) begin : g_ok
      assert_out_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (cyc >= 4'd1 && $rose(irq_out[k])) |->
            $past((pend_a & mask_a) != '0 || (pend_b & mask_b) != '0));
   end
endmodule

bind irq_route_ctrl irq_route_chk #(
   .NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT), .FIELD_W(FIELD_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
   .pend_a(pend_a), .pend_b(pend_b), .mask_a(mask_a), .mask_b(mask_b),
   .route_f(route_f), .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq_out(irq_out)
);

// File: tb/sim_irq_route_ctrl.sv
`timescale 1ns/1ps
module sim_irq_route_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] src_a = '0, src_b = '0;
   logic [5:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [4:0]  irq_out;

   int checks = 0;
   int errors = 0;
   bit live = 1'b0;

   always #2.5 clk = ~clk;

   irq_route_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_out(irq_out));

   // ---------------- behavioural reference ----------------
   int          rt [2][16];
   logic [15:0] m_s1a, m_s1b, m_pa, m_pb, m_ma, m_mb;
   logic [4:0]  m_irq;
   logic [4:0]  m_nx;

   function automatic int slot_pin(input int r, input int s);
      case (r)
         0: return (s == 4) ? 8 : s;
         1: return (s == 0) ? 9 : (s == 2) ? 11 : (s == 3) ? 12 : -1;
         2: return (s < 2) ? s : s + 1;
         default: return 6 + s;
      endcase
   endfunction

   function automatic int word_of(input logic [5:0] a);
      case (a)
         6'h04: return 0;
         6'h06: return 1;
         6'h1C: return 2;
         6'h1E: return 3;
         default: return -1;
      endcase
   endfunction

   function automatic logic [15:0] exp_rd(input logic [5:0] a);
      logic [15:0] w;
      int r;
      w = '0;
      r = word_of(a);
      if (a == 6'h00) w = m_pa;
      else if (a == 6'h0C) w = m_ma;
      else if (a == 6'h20) w = m_pb;
      else if (a == 6'h26) w = m_mb;
      else if (r >= 0) begin
         for (int s = 0; s < 5; s++)
            if (slot_pin(r, s) >= 0) w[3*s +: 3] = 3'(rt[r / 2][slot_pin(r, s)]);
      end
      return w;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int g = 0; g < 2; g++) for (int p = 0; p < 16; p++) rt[g][p] = 0;
         rt[0][2] = 1;
         rt[1][0] = 2;
         m_s1a <= '0; m_s1b <= '0; m_pa <= '0; m_pb <= '0;
         m_ma <= '0; m_mb <= '0; m_irq <= '0;
      end else begin
         m_nx = '0;
         for (int p = 0; p < 16; p++) begin
            if (m_pa[p] && m_ma[p]) m_nx[rt[0][p]] = 1'b1;
            if (m_pb[p] && m_mb[p]) m_nx[rt[1][p]] = 1'b1;
         end
         m_irq <= m_nx;
         m_s1a <= src_a; m_s1b <= src_b;
         m_pa <= m_s1a;  m_pb <= m_s1b;
         if (bus_we) begin
            if (bus_addr == 6'h0C) m_ma <= bus_wdata;
            if (bus_addr == 6'h26) m_mb <= bus_wdata;
            if (word_of(bus_addr) >= 0) begin
               for (int s = 0; s < 5; s++) begin
                  if (slot_pin(word_of(bus_addr), s) >= 0 && int'(bus_wdata[3*s +: 3]) <= 4)
                     rt[word_of(bus_addr) / 2][slot_pin(word_of(bus_addr), s)] = int'(bus_wdata[3*s +: 3]);
               end
            end
         end
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // R7 R3: every clock the outputs follow the reference
   always @(negedge clk) begin
      if (live) chk(16'(irq_out), 16'(m_irq), "R7 per-cycle irq_out");
   end

   task automatic wr(input logic [5:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd_lit(input logic [5:0] a, input logic [15:0] exp, input string tag);
      @(negedge clk);
      bus_addr = a;
      #1 chk(bus_rdata, exp, tag);
   endtask

   task automatic rd_model(input logic [5:0] a, input string tag);
      @(negedge clk);
      bus_addr = a;
      #1 chk(bus_rdata, exp_rd(a), tag);
   endtask

   task automatic srcs(input logic [15:0] a, input logic [15:0] b);
      @(negedge clk);
      src_a = a; src_b = b;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic irq_lit(input logic [4:0] exp, input string tag);
      #1 chk(16'(irq_out), 16'(exp), tag);
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] lf;
      logic [5:0]  pick [7];
      pick = '{6'h04, 6'h06, 6'h1C, 6'h1E, 6'h0C, 6'h26, 6'h00};

      idle(3);
      rst_n = 1'b1;
      live = 1'b1;

      // R1 reset state, R9 default routes
      rd_lit(6'h0C, 16'h0000, "R1 mask A reset");
      rd_lit(6'h26, 16'h0000, "R1 mask B reset");
      irq_lit(5'b00000, "R1 irq reset");
      rd_lit(6'h04, 16'h0040, "R9 route word 0x04 reset");
      rd_lit(6'h1C, 16'h0002, "R9 route word 0x1C reset");
      rd_lit(6'h06, 16'h0000, "R9 route word 0x06 reset");
      rd_lit(6'h1E, 16'h0000, "R9 route word 0x1E reset");

      // R8 enable words
      wr(6'h0C, 16'hA5C3);
      rd_lit(6'h0C, 16'hA5C3, "R8 mask A readback");
      wr(6'h26, 16'hFFFF);
      rd_lit(6'h26, 16'hFFFF, "R8 mask B readback");

      // R2 pending capture and write immunity
      srcs(16'h0005, 16'h8001);
      idle(3);
      rd_lit(6'h00, 16'h0005, "R2 pending A");
      rd_lit(6'h20, 16'h8001, "R2 pending B");
      wr(6'h00, 16'hFFFF);
      wr(6'h20, 16'h0000);
      rd_lit(6'h00, 16'h0005, "R2 pending A after write");
      rd_lit(6'h20, 16'h8001, "R2 pending B after write");

      // R3/R7: A0->INT0, B0->INT2, B15->INT0
      idle(1);
      irq_lit(5'b00101, "R7 combined outputs");
      wr(6'h0C, 16'h0000);
      wr(6'h26, 16'h0000);
      idle(1);
      irq_lit(5'b00000, "R3 disabled sources");

      // R9 default routes drive INT1 and INT2
      wr(6'h0C, 16'h0004);
      srcs(16'h0004, 16'h0000);
      idle(4);
      irq_lit(5'b00010, "R9 bank A line 2 to INT1");
      wr(6'h0C, 16'h0000);
      wr(6'h26, 16'h0001);
      srcs(16'h0000, 16'h0001);
      idle(4);
      irq_lit(5'b00100, "R9 bank B line 0 to INT2");

      // R4 field positions
      wr(6'h26, 16'h0000);
      wr(6'h04, 16'h08D1);
      rd_lit(6'h04, 16'h08D1, "R4 route word 0x04 readback");
      wr(6'h0C, 16'hFFFF);
      srcs(16'h0008, 16'h0000);
      idle(4);
      irq_lit(5'b10000, "R4 bank A line 3 to INT4");
      srcs(16'h0002, 16'h0000);
      idle(4);
      irq_lit(5'b00100, "R4 bank A line 1 to INT2");
      wr(6'h1E, 16'h3000);
      rd_lit(6'h1E, 16'h3000, "R4 route word 0x1E readback");
      wr(6'h0C, 16'h0000);
      wr(6'h26, 16'hFFFF);
      srcs(16'h0000, 16'h0400);
      idle(4);
      irq_lit(5'b01000, "R4 bank B line 10 to INT3");

      // R5 illegal values keep old field, others update
      wr(6'h06, 16'h00C7);
      rd_lit(6'h06, 16'h00C0, "R5 mixed legal/illegal write");
      wr(6'h06, 16'hFFFF);
      rd_lit(6'h06, 16'h00C0, "R5 all-illegal write");
      wr(6'h04, 16'hFFFF);
      rd_lit(6'h04, 16'h08D1, "R6 unused bit 15 reads 0");

      // R6 line without a field goes to INT0
      wr(6'h26, 16'h0000);
      wr(6'h0C, 16'hFFFF);
      srcs(16'h0010, 16'h0000);
      idle(4);
      irq_lit(5'b00001, "R6 bank A line 4 to INT0");

      // R10 unmapped addresses
      rd_lit(6'h02, 16'h0000, "R10 unmapped read");
      wr(6'h08, 16'h0000);
      rd_lit(6'h0C, 16'hFFFF, "R10 unmapped write no effect");

      // concurrent writes and source changes against the model
      lf = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         @(negedge clk);
         src_a = lf;
         src_b = {lf[7:0], lf[15:8]};
         bus_we = lf[0] & lf[3];
         bus_addr = pick[int'(lf[6:4]) % 7];
         bus_wdata = {lf[3:0], lf[15:4]};
         #1;
         if (!bus_we) chk(bus_rdata, exp_rd(bus_addr), "R2 R8 R4 random readback");
      end
      @(negedge clk);
      bus_we = 1'b0;
      for (int r = 0; r < 7; r++) rd_model(pick[r], "R5 final readback");
      idle(4);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule